// File: doc/BRIEF.md
# Register-Programmed Pulse-Width Modulator

This block drives a single pulse-width-modulated output from one 32-bit control word. A prescaler stretches each step of an 8-bit step counter to a programmable number of source clocks, so every output period is 256 steps long. The output is high while the step counter is below the programmed pulse width. A separate override bit holds the output high for the whole period.

Software writes the whole control word in one cycle and can read it back. A write takes effect on the next clock. It restarts the period from step zero and does not wait for the running period to finish. Clearing the enable bit drops the output at once.

Top module: `regpwm_top`

## Requirements
- R1: After synchronous reset the control word reads 0 and `pwm_out` is 0.
- R2: The control word keeps the divider in bits [12:0], the pulse width in bits [23:16], the full-duty override in bit 24 and the enable in bit 31. Bits [30:25] and [15:13] read as 0 whatever was written to them.
- R3: While enabled with bit 24 set, `pwm_out` is 1 in every cycle, whatever the pulse-width field holds.
- R4: The step counter counts 0 to 255 and then wraps to 0, so one output period is 256 steps.
- R5: Each step lasts divider+1 clock cycles, so with a divider of 0 the counter advances on every clock.
- R6: While enabled with bit 24 clear, `pwm_out` is 1 exactly while the step counter is below the pulse width. A pulse width of 0 gives a constant 0.
- R7: When a write clears the enable bit, `pwm_out` is 0 from the cycle after the write and stays 0, even in the middle of a period.
- R8: A write while the block is running applies the new divider, pulse width and override from the cycle after the write. The running period is not completed.
- R9: Every write resets the prescaler and the step counter to 0. In the cycle after the write the block is at step 0 of a new period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Control word readback |
| pwm_out | output | 1 | Modulated output, active high |

## Verification
A register write can land in the same cycle as a prescaler tick that would advance or wrap the step counter. In that cycle the restart must win, and the counter must read step 0 in the next cycle. The bench provokes this in two ways. It writes at random points during long runs with small dividers, so the write often meets a tick. It also makes directed writes exactly at the end of a period. A bench model counts the cycles since the last write and derives the expected output from that count, so a missed restart or a late step shows up as a mismatch on `pwm_out`.

// File: rtl/regpwm_pkg.sv
package regpwm_pkg;

    localparam int WORD_W   = 32;
    localparam int DIV_W    = 13;
    localparam int WIDTH_W  = 8;
    localparam int DIV_LSB  = 0;
    localparam int WID_LSB  = 16;
    localparam int FULL_BIT = 24;
    localparam int EN_BIT   = 31;
    localparam int STEPS    = 1 << WIDTH_W;

    typedef struct packed {
        logic               en;
        logic               full;
        logic [WIDTH_W-1:0] width;
        logic [DIV_W-1:0]   div;
    } pwm_cfg_t;

    function automatic pwm_cfg_t cfg_from_word(input logic [WORD_W-1:0] w);
        pwm_cfg_t c;
        c.en    = w[EN_BIT];
        c.full  = w[FULL_BIT];
        c.width = w[WID_LSB +: WIDTH_W];
        c.div   = w[DIV_LSB +: DIV_W];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] word_from_cfg(input pwm_cfg_t c);
        logic [WORD_W-1:0] w;
        w                      = '0;
        w[EN_BIT]              = c.en;
        w[FULL_BIT]            = c.full;
        w[WID_LSB +: WIDTH_W]  = c.width;
        w[DIV_LSB +: DIV_W]    = c.div;
        return w;
    endfunction

endpackage

// File: rtl/regpwm_cfg_reg.sv
module regpwm_cfg_reg
    import regpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output pwm_cfg_t          cfg,
    output logic [WORD_W-1:0] rd_word,
    output logic              restart
);

    pwm_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= cfg_from_word(wr_data);
        end
    end

    assign cfg     = cfg_q;
    assign rd_word = word_from_cfg(cfg_q);
    assign restart = wr_en;

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_word[30:25] == '0) && (rd_word[15:13] == '0)); // R2

endmodule

// File: rtl/regpwm_prescaler.sv
module regpwm_prescaler #(
    parameter int DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] pre_q;
    logic             at_end;

    assign at_end = (pre_q >= div);
    assign tick   = run && at_end;

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            pre_q <= '0;
        end else if (at_end) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    AST_PRESCALE_BOUND: assert property (@(posedge clk) disable iff (rst)
        pre_q <= div); // R5

    AST_PRESCALE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        restart |=> (pre_q == '0)); // R9

endmodule

// File: rtl/regpwm_step_cnt.sv
module regpwm_step_cnt #(
    parameter int WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               restart,
    input  logic               tick,
    input  logic               full,
    input  logic [WIDTH_W-1:0] width,
    output logic               pwm
);

    logic [WIDTH_W-1:0] step_q;

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            step_q <= '0;
        end else if (tick) begin
            step_q <= step_q + 1'b1;
        end
    end

    assign pwm = run && (full || (step_q < width));

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !restart) |=> (step_q == WIDTH_W'($past(step_q) + 1'b1))); // R4

    AST_STEP_CLEAR: assert property (@(posedge clk) disable iff (rst)
        restart |=> (step_q == '0)); // R9

endmodule

// File: rtl/regpwm_top.sv
module regpwm_top
    import regpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              pwm_out
);

    pwm_cfg_t cfg;
    logic     restart;
    logic     tick;

    regpwm_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg),
        .rd_word (rd_data),
        .restart (restart)
    );

    regpwm_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (cfg.en),
        .restart (restart),
        .div     (cfg.div),
        .tick    (tick)
    );

    regpwm_step_cnt #(.WIDTH_W(WIDTH_W)) u_step (
        .clk     (clk),
        .rst     (rst),
        .run     (cfg.en),
        .restart (restart),
        .tick    (tick),
        .full    (cfg.full),
        .width   (cfg.width),
        .pwm     (pwm_out)
    );

    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (rd_data[EN_BIT] && rd_data[FULL_BIT]) |-> pwm_out); // R3

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        !rd_data[EN_BIT] |-> !pwm_out); // R7

    AST_ZERO_WIDTH_LOW: assert property (@(posedge clk) disable iff (rst)
        (!rd_data[FULL_BIT] && rd_data[23:16] == '0) |-> !pwm_out); // R6

endmodule

// File: tb/regpwm_top_tb_top.sv
module regpwm_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pwm_out;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    int unsigned cyc      = 0;
    logic        done     = 1'b0;

    logic [31:0] m_word = '0;
    int unsigned m_t    = 0;

    always #5 clk = ~clk;

    regpwm_top dut_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .pwm_out (pwm_out)
    );

    function automatic logic [31:0] mask_word(input logic [31:0] w);
        return w & 32'h81FF_1FFF;
    endfunction

    function automatic logic exp_out(input logic [31:0] w, input int unsigned t);
        int unsigned div  = w[12:0];
        int unsigned step = (t / (div + 1)) % 256;
        if (!w[31]) return 1'b0;
        if (w[24])  return 1'b1;
        return step < w[23:16];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    task automatic check_out();
        string req;
        if (!m_word[31])                 req = "R7";
        else if (m_word[24])             req = "R3";
        else if (m_word[23:16] == 8'd0)  req = "R6";
        else                             req = "R5/R6";
        check(req, {31'd0, pwm_out}, {31'd0, exp_out(m_word, m_t)});
    endtask

    task automatic do_write(input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(posedge clk);
        m_word = mask_word(d);
        m_t    = 0;
        @(negedge clk);
        wr_en = 1'b0;
        check("R2", rd_data, m_word);
        check_out();
    endtask

    task automatic run(input int unsigned n);
        for (int unsigned i = 0; i < n; i++) begin
            @(posedge clk);
            m_t++;
            @(negedge clk);
            check_out();
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        wait (cyc > 190000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", rd_data, 32'd0);
        check("R1", {31'd0, pwm_out}, 32'd0);

        // R2 reserved bits read zero
        do_write(32'hFFFF_FFFF);
        check("R2", rd_data, 32'h81FF_1FFF);
        do_write(32'h7E00_E000);
        check("R2", rd_data, 32'd0);

        // R4 R5 R6 divider 0, half duty, two full periods plus
        do_write(32'h8080_0000);
        run(600);
        // R5 divider 2, width 3
        do_write(32'h8003_0002);
        run(1600);
        // R6 width 0 stays low
        do_write(32'h8000_0001);
        run(600);
        // R6 width 255
        do_write(32'h80FF_0000);
        run(520);
        // R3 override ignores width 0
        do_write(32'h8100_0003);
        run(400);
        // R7 disable mid-period
        do_write(32'h8040_0001);
        run(37);
        do_write(32'h0040_0001);
        run(300);
        // R9 write exactly at period wrap (divider 0, 256 steps)
        do_write(32'h8010_0000);
        run(255);
        do_write(32'h8020_0000);
        run(300);
        // R8 rewrite mid-period
        do_write(32'h80C0_0001);
        run(100);
        do_write(32'h8008_0000);
        run(300);

        // R8 R9 random writes at random points
        for (int k = 0; k < 60; k++) begin
            logic [31:0] w;
            w = $urandom();
            w[12:0] = 13'($urandom_range(0, 3));
            if ($urandom_range(0, 3) != 0) w[31] = 1'b1;
            if ($urandom_range(0, 4) != 0) w[24] = 1'b0;
            do_write(w);
            run($urandom_range(1, 1200));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule